// File: doc/BRIEF.md
# System Clock Source Selector with Prescaler

This block picks the source that feeds the system clock and turns it into a clock-enable pulse for the logic downstream. Software writes a single 32-bit control word. The word holds a source code, a power-of-two prescaler, a pre-divider that applies only to the 96 MHz internal oscillator, and four oscillator enables. Reading the word returns those fields together with live ready flags for each source and a clock-ready flag for the switchover.

A switch to a new source is a handshake. The requested code is stored at once, and the clock-ready flag drops. The source in use stays the same until that oscillator reports that it is running. The output enable is generated by counting cycles: one pulse every 2^e cycles, where e is the prescaler exponent plus, when the 96 MHz source is active, the pre-divider exponent. Whenever e changes, the count starts again.

Top module: `sysclk_selector`

## Requirements
- R1: After reset the control word reads 0x00000008 while all source ready inputs are low. `activeSrc` is 0, meaning no source is in use, and `oscEn` and `sysClkEn` are low.
- R2: Bits [11:9] hold the source code: 2 = 32 MHz crystal, 3 = low-frequency internal, 4 = 96 MHz internal, 5 = 8 MHz internal, 6 = 32 kHz crystal, 7 = external pin. Bits [11:9] read back the last valid code written. `activeSrc` takes that code once the switch completes.
- R3: Bit 13 (clock ready) reads 0 after reset until a first switch completes. It reads 0 from the cycle after any write that requests a code different from the active one, until that switch completes. It reads 1 when the switch completes.
- R4: A switch completes one clock edge after the requested source's `srcRdy` bit (indexed by code) is seen high, and not earlier than one edge after the write. Until then `activeSrc` holds the previous source. A new valid code written while a switch is pending replaces the target.
- R5: Writing code 0 or 1 to bits [11:9] leaves both the requested and the active source unchanged. The other fields in that same write still take effect.
- R6: Bits [8:6] hold n. With the prescaler alone in effect, `sysClkEn` is a one-cycle pulse every 2^n cycles (n = 0 gives a pulse every cycle).
- R7: Bits [15:14] hold p. When the active source is code 4, the pulse period is 2^(n+p). For any other source, p has no effect on the period.
- R8: When the total exponent e changes, the count restarts. For a change taking effect at clock edge k, `sysClkEn` is low in the cycle after edge k, and its first pulse is in the cycle after edge k+2^e.
- R9: Bits 16, 17, 19 and 20 are the enables for the 32 MHz crystal, 32 kHz crystal, 96 MHz internal and 8 MHz internal oscillators, and they drive `oscEn[0]` to `oscEn[3]`. Read-only bits 24, 25, 27, 28, 29 and 31 reflect `srcRdy` for codes 2, 6, 4, 5, 3 and 7.
- R10: `sysClkEn` stays low while no source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word write data |
| rdData | output | 32 | Control word read-back, including status bits |
| srcRdy | input | 8 | Per-source running flag, indexed by source code (bits 0 and 1 unused) |
| oscEn | output | 4 | Oscillator enables: 32 MHz crystal, 32 kHz crystal, 96 MHz internal, 8 MHz internal |
| activeSrc | output | 3 | Source code currently in use, 0 when none |
| sysClkEn | output | 1 | Divided clock-enable pulse |

## Verification
Field writes, enables and the pending flag are visible in the cycle right after the write edge. A switchover shows on `activeSrc` one edge after the target's ready input is seen high, so a switch whose source is already ready completes two negative edges after the write is driven. After an exponent change, the first `sysClkEn` pulse is due 2^e+1 sampling points after the write. When the change comes from a switch to the 96 MHz source, the count runs from the completion edge instead. The bench drives and samples only on falling edges. It counts those sampling points from the write and checks both the first-pulse delay and the gap that follows it against 2^e, which it computes from the fields it wrote.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int DIV_LSB = 6;
  localparam int DIV_W   = 3;
  localparam int SEL_LSB = 9;
  localparam int SEL_W   = 3;
  localparam int RDY_BIT = 13;
  localparam int PRE_LSB = 14;
  localparam int PRE_W   = 2;
  localparam int NUM_OSC = 4;
  localparam int NUM_SRC = 8;

  localparam logic [31:0] CTRL_RST = 32'h0000_0008;

  localparam logic [SEL_W-1:0] SRC_NONE    = 3'd0;
  localparam logic [SEL_W-1:0] SRC_FIRST   = 3'd2;
  localparam logic [SEL_W-1:0] SRC_RC_FAST = 3'd4;

  localparam int OSC_EN_POS [NUM_OSC] = '{16, 17, 19, 20};
  localparam int RDY_POS    [NUM_SRC] = '{0, 0, 24, 29, 27, 28, 25, 31};

  localparam int MAX_EXP = (2**DIV_W - 1) + (2**PRE_W - 1);
  localparam int EXP_W   = $clog2(MAX_EXP + 1);

  typedef struct packed {
    logic             run;
    logic             restart;
    logic [EXP_W-1:0] expo;
  } presc_ctl_t;

  function automatic logic [31:0] storedMask();
    logic [31:0] m;
    m = CTRL_RST;
    m = m | ({{(32-DIV_W){1'b0}}, {DIV_W{1'b1}}} << DIV_LSB);
    m = m | ({{(32-PRE_W){1'b0}}, {PRE_W{1'b1}}} << PRE_LSB);
    for (int i = 0; i < NUM_OSC; i++) m[OSC_EN_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  input  logic [NUM_SRC-1:0] srcRdy,
  output logic [31:0]        rdData,
  output logic [NUM_OSC-1:0] oscEn,
  output logic [SEL_W-1:0]   activeSrc,
  output presc_ctl_t         prescCtl
);
  localparam logic [31:0] WR_MASK = storedMask();

  logic [31:0]      ctrlQ;
  logic [SEL_W-1:0] reqQ;
  logic [SEL_W-1:0] activeQ;
  logic             pendQ;
  logic [EXP_W-1:0] expoQ;
  logic [EXP_W-1:0] expo;
  logic [SEL_W-1:0] newSel;
  logic             selValid;
  logic [31:0]      rdyBits;

  assign newSel   = wrData[SEL_LSB +: SEL_W];
  assign selValid = newSel >= SRC_FIRST;

  always_comb begin
    expo = EXP_W'(ctrlQ[DIV_LSB +: DIV_W]);
    if (activeQ == SRC_RC_FAST) expo = expo + EXP_W'(ctrlQ[PRE_LSB +: PRE_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_RST & WR_MASK;
      reqQ    <= SRC_NONE;
      activeQ <= SRC_NONE;
      pendQ   <= 1'b0;
      expoQ   <= '0;
    end else begin
      expoQ <= expo;
      if (wrEn) ctrlQ <= (ctrlQ & ~WR_MASK) | (wrData & WR_MASK);
      if (wrEn && selValid) begin
        reqQ  <= newSel;
        pendQ <= (newSel != activeQ);
      end else if (pendQ && srcRdy[reqQ]) begin
        activeQ <= reqQ;
        pendQ   <= 1'b0;
      end
    end
  end

  always_comb begin
    rdyBits = '0;
    for (int c = SRC_FIRST; c < NUM_SRC; c++) rdyBits[RDY_POS[c]] = srcRdy[c];
  end

  always_comb begin
    rdData = ctrlQ | rdyBits;
    rdData[SEL_LSB +: SEL_W] = reqQ;
    rdData[RDY_BIT] = !pendQ && (activeQ != SRC_NONE);
  end

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
    assign oscEn[i] = ctrlQ[OSC_EN_POS[i]];
  end

  assign activeSrc        = activeQ;
  assign prescCtl.run     = activeQ != SRC_NONE;
  assign prescCtl.restart = expo != expoQ;
  assign prescCtl.expo    = expo;
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_pkg::*;
#(
  parameter int CNT_W = MAX_EXP
) (
  input  logic       clk,
  input  logic       rstN,
  input  presc_ctl_t prescCtl,
  output logic       tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // 2^e - 1; the shift wraps to zero at e = CNT_W, so the subtraction gives all ones
  assign limit = (CNT_W'(1) << prescCtl.expo) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!prescCtl.run || prescCtl.restart || cnt == limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign tick = prescCtl.run && !prescCtl.restart && (cnt == limit);
endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector
  import sysclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [7:0]  srcRdy,
  output logic [3:0]  oscEn,
  output logic [2:0]  activeSrc,
  output logic        sysClkEn
);
  presc_ctl_t prescCtl;

  sysclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .srcRdy(srcRdy),
    .rdData(rdData), .oscEn(oscEn), .activeSrc(activeSrc), .prescCtl(prescCtl)
  );

  sysclk_prescaler #(.CNT_W(MAX_EXP)) u_presc (
    .clk(clk), .rstN(rstN), .prescCtl(prescCtl), .tick(sysClkEn)
  );
endmodule

// File: rtl/sysclk_selector_chk.sv
module sysclk_selector_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [7:0]  srcRdy,
  input logic [2:0]  activeSrc,
  input logic        sysClkEn
);
  logic [7:0] rdyPrev;
  always_ff @(posedge clk) rdyPrev <= srcRdy;

  // R4
  switch_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeSrc != $past(activeSrc)) |-> rdyPrev[activeSrc]);

  // R3
  ready_on_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeSrc != $past(activeSrc)) |-> rdData[13]);

  // R3
  ready_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[13]) |-> (activeSrc != 3'd0));

  // R10
  no_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeSrc == 3'd0) |-> !sysClkEn);

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[11:9] < 3'd2) |=> (rdData[11:9] == $past(rdData[11:9])));

  // R8
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[8:6] != rdData[8:6] && wrData[15:14] == rdData[15:14]) |=> !sysClkEn);
endmodule

bind sysclk_selector sysclk_selector_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .srcRdy(srcRdy), .activeSrc(activeSrc), .sysClkEn(sysClkEn)
);

// File: tb/tb_sysclk_selector.sv
module tb_sysclk_selector;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [7:0]  srcRdy;
  logic [3:0]  oscEn;
  logic [2:0]  activeSrc;
  logic        sysClkEn;

  int nChecks = 0;
  int nErr = 0;
  logic [31:0] cfg;

  always #10 clk = ~clk;

  sysclk_selector dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .srcRdy(srcRdy), .oscEn(oscEn), .activeSrc(activeSrc), .sysClkEn(sysClkEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wrData = v;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] setField(input logic [31:0] w, input int lsb,
                                           input int width, input int val);
    logic [31:0] m;
    m = ((32'd1 << width) - 32'd1) << lsb;
    return (w & ~m) | ((32'(val) << lsb) & m);
  endfunction

  task automatic measFirst(input int e, input string req);
    int j;
    j = 1;
    while (!sysClkEn && j < 2100) begin
      @(negedge clk);
      j++;
    end
    check(req, 32'(j), 32'((1 << e) + 1));
  endtask

  task automatic measGap(input int e, input string req);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sysClkEn && k < 2100);
    check(req, 32'(k), 32'(1 << e));
  endtask

  task automatic t_reset();
    check("R1 ctrl word", rdData, 32'h0000_0008);
    check("R1 active", 32'(activeSrc), 0);
    check("R1 osc enables", 32'(oscEn), 0);
    check("R1 pulse", 32'(sysClkEn), 0);
    check("R3 ready after reset", 32'(rdData[13]), 0);
  endtask

  task automatic t_idle();
    int seen;
    seen = 0;
    cfg = setField(32'h8, 6, 3, 0);
    wr(cfg);
    for (int i = 0; i < 10; i++) begin
      if (sysClkEn) seen++;
      @(negedge clk);
    end
    check("R10 no pulse idle", 32'(seen), 0);
  endtask

  task automatic t_enables();
    srcRdy = 8'b1010_1100;
    cfg = cfg | (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 19) | (32'd1 << 20);
    wr(cfg);
    check("R9 all enables", 32'(oscEn), 32'hF);
    check("R9 ready mirrors", rdData & 32'hBB00_0000, 32'hB100_0000);
    cfg = cfg & ~(32'd1 << 17);
    wr(cfg);
    check("R9 one enable off", 32'(oscEn), 32'hD);
    srcRdy = 8'h0;
    @(negedge clk);
    check("R9 ready cleared", rdData & 32'hBB00_0000, 0);
  endtask

  task automatic t_switch();
    cfg = setField(cfg, 9, 3, 6);
    wr(cfg);
    check("R3 ready low pending", 32'(rdData[13]), 0);
    check("R4 no source yet", 32'(activeSrc), 0);
    repeat (4) @(negedge clk);
    check("R4 still waiting", 32'(activeSrc), 0);
    srcRdy[6] = 1'b1;
    @(negedge clk);
    check("R2 active crystal lf", 32'(activeSrc), 6);
    check("R3 ready after switch", 32'(rdData[13]), 1);
    check("R2 select readback", 32'(rdData[11:9]), 6);
    cfg = setField(cfg, 9, 3, 2);
    wr(cfg);
    check("R3 ready drops", 32'(rdData[13]), 0);
    repeat (3) @(negedge clk);
    check("R4 previous kept", 32'(activeSrc), 6);
    srcRdy[5] = 1'b1;
    cfg = setField(cfg, 9, 3, 5);
    wr(cfg);
    check("R4 retarget pending", 32'(activeSrc), 6);
    @(negedge clk);
    check("R4 retarget done", 32'(activeSrc), 5);
    check("R3 ready retarget", 32'(rdData[13]), 1);
  endtask

  task automatic t_reserved();
    logic [31:0] w;
    w = setField(setField(cfg, 9, 3, 1), 6, 3, 2);
    wr(w);
    check("R5 select kept", 32'(rdData[11:9]), 5);
    check("R5 active kept", 32'(activeSrc), 5);
    check("R5 ready kept", 32'(rdData[13]), 1);
    check("R5 divider applied", 32'(rdData[8:6]), 2);
    cfg = setField(cfg, 6, 3, 2);
  endtask

  task automatic t_presc();
    int ns [3] = '{0, 3, 7};
    foreach (ns[i]) begin
      cfg = setField(cfg, 6, 3, ns[i]);
      wr(cfg);
      measFirst(ns[i], "R8 first pulse");
      measGap(ns[i], "R6 period");
    end
  endtask

  task automatic t_prediv();
    cfg = setField(setField(cfg, 6, 3, 1), 14, 2, 3);
    wr(cfg);
    measFirst(1, "R7 pre ignored first");
    measGap(1, "R7 pre ignored period");
    srcRdy[4] = 1'b1;
    cfg = setField(cfg, 9, 3, 4);
    wr(cfg);
    @(negedge clk);
    check("R7 fast source active", 32'(activeSrc), 4);
    measFirst(4, "R7 combined first");
    measGap(4, "R7 combined period");
    cfg = setField(setField(cfg, 6, 3, 2), 14, 2, 1);
    wr(cfg);
    measFirst(3, "R7 mixed first");
    measGap(3, "R7 mixed period");
    cfg = setField(setField(cfg, 6, 3, 7), 14, 2, 3);
    wr(cfg);
    measFirst(10, "R7 max first");
    measGap(10, "R7 max period");
  endtask

  initial begin
    rstN = 1'b0;
    wrEn = 1'b0;
    wrData = '0;
    srcRdy = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_enables();
    t_switch();
    t_reserved();
    t_presc();
    t_prediv();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule